// File: doc/BRIEF.md
# Regulator soft-start sequencer

This block is the digital start-up controller of a multi-phase voltage regulator. It decides when the regulator may run. It walks the converter through a fixed settling wait and then through a linear rise of the reference code. It holds the power stage in high impedance until the rising reference catches up with any charge already on the output. The analog reference DAC, the comparators, the modulator and the gate drivers sit outside. They exchange with this block only ticks, flags and codes.

Four conditions must hold at once before a start: the supply-good flag, the enable comparator, the logic-level enable, and a valid voltage code. The all-ones code means that no load is fitted, so it does not count as valid. Once they hold, the sequencer counts a fixed number of switching-cycle ticks at a zero reference. It then raises the reference code by one LSB on each timebase tick, up to the code it latched at start. During start-up a remote-sense offset code is applied in full. Once the ramp begins, that offset steps down to zero over a fixed number of switching cycles. If any condition is lost, the sequencer falls back to off, and the next start repeats the whole sequence. A brief all-ones code is tolerated. A sustained one shuts the block down.

Top module: `vreg_softstart`

## Requirements
- R1: The sequencer stays off while any of these holds: supply_ok low, en_cmp low, en_logic low, or vid equal to 6'b111111. Off means ref_code 0, pwm_hiz 1, ss_done 0 and offset_code equal to OFS_MAX.
- R2: The sequence starts at the first clock edge at which all four start conditions hold. No extra cycle is spent first. All later timing counts from that edge.
- R3: After the start edge, ref_code stays 0 for DLY_CYC pulses of sw_tick. The ramp phase begins on the edge that samples the DLY_CYC-th pulse, and clock cycles without a pulse do not advance the wait.
- R4: In the ramp phase, ref_code rises from 0 by exactly one on each clock edge that samples step_tick high. It stops at the target, which is the unsigned value of vid latched at the start edge.
- R5: A target T is reached T step ticks after the ramp begins. ss_done rises on the clock edge after ref_code equals T. A target of 0 gives ss_done one edge after the ramp phase begins.
- R6: pwm_hiz is 1 while off and throughout the wait, and prebias_ok is ignored there. In the ramp phase, the first edge that samples prebias_ok high drives pwm_hiz to 0. It stays 0 until the sequence stops. Reaching ss_done also drives it to 0.
- R7: offset_code holds OFS_MAX from the start edge through the wait. Once the ramp begins, it drops by one every OFS_CYC/OFS_MAX sw_tick pulses and then holds at 0. It therefore reaches 0 OFS_CYC pulses after the ramp begins.
- R8: A vid of 6'b111111 sampled on NL_DLY+1 consecutive edges shuts the running sequence down at that last edge. Shorter bursts leave it running. After such a shutdown, any other code starts a fresh sequence from the wait phase.
- R9: If supply_ok, en_cmp or en_logic goes low during any phase, the block is off after the next edge. A later restart repeats the full wait.
- R10: Once ss_done is high, it stays high and ref_code holds the latched target until the sequence stops. Changes to vid after the start edge, other than a shutdown under R8, leave the target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Bias supply above its power-on threshold |
| en_cmp | input | 1 | Enable comparator output |
| en_logic | input | 1 | Logic-level enable |
| vid | input | 6 | Requested voltage code; all ones means no load |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| step_tick | input | 1 | One-clock pulse per ramp step period |
| prebias_ok | input | 1 | Comparator: reference has reached the existing output level |
| ref_code | output | 6 | Reference code to the DAC |
| offset_code | output | $clog2(OFS_MAX+1) | Remote-sense offset code |
| pwm_hiz | output | 1 | Tri-state request for the PWM outputs |
| ss_done | output | 1 | Soft-start complete |

## Verification
A corrupted phase state or delay count shows up as a ramp that starts one or more edges early or late. With ticks every cycle, the bench sees this within DLY_CYC+1 edges of the start. A bad latched target, or a faulty step counter, bends the staircase of ref_code. It ends on the wrong code or raises ss_done at the wrong edge, and the bench compares every edge against the arithmetic value for every target from 0 to 62. A stuck release flag or offset divider shows on pwm_hiz or offset_code at the first edge where the expected value departs from its start value.

// File: rtl/vreg_ss_pkg.sv
package vreg_ss_pkg;
  localparam int VID_W = 6;

  typedef enum logic [1:0] {
    SS_OFF   = 2'd0,
    SS_DELAY = 2'd1,
    SS_RAMP  = 2'd2,
    SS_DONE  = 2'd3
  } ss_state_e;

  // switching cycles per offset LSB during the decay
  function automatic int ofs_step_div(input int cyc, input int mx);
    int d;
    d = (mx < 1) ? cyc : cyc / mx;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic vid_noload(input logic [VID_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/vreg_ss_enable.sv
module vreg_ss_enable
  import vreg_ss_pkg::*;
#(
  parameter int NL_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             en_cmp,
  input  logic             en_logic,
  input  logic [VID_W-1:0] vid,
  output logic             start_ok,
  output logic             stop_req
);
  localparam int NL_W = cnt_width(NL_DLY + 1);

  logic [NL_W-1:0] nl_cnt;
  logic            nl_now;
  logic            nl_hit;

  assign nl_now = vid_noload(vid);
  assign nl_hit = nl_now && (nl_cnt == NL_W'(NL_DLY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nl_cnt <= '0;
    end else if (!nl_now) begin
      nl_cnt <= '0;
    end else if (nl_cnt != NL_W'(NL_DLY)) begin
      nl_cnt <= nl_cnt + NL_W'(1);
    end
  end

  assign start_ok = supply_ok && en_cmp && en_logic && !nl_now;
  assign stop_req = !supply_ok || !en_cmp || !en_logic || nl_hit;
endmodule

// File: rtl/vreg_ss_ramp.sv
module vreg_ss_ramp
  import vreg_ss_pkg::*;
#(
  parameter int DLY_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             stop_req,
  input  logic             sw_tick,
  input  logic             step_tick,
  input  logic             prebias_ok,
  input  logic [VID_W-1:0] vid,
  output ss_state_e        st,
  output logic [VID_W-1:0] ref_code,
  output logic             pwm_rel
);
  localparam int DLY_W = cnt_width(DLY_CYC);

  logic [DLY_W-1:0] dly_cnt;
  logic [VID_W-1:0] tgt;
  logic             dly_last;

  assign dly_last = sw_tick && (dly_cnt == DLY_W'(DLY_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SS_OFF;
      dly_cnt  <= '0;
      ref_code <= '0;
      tgt      <= '0;
      pwm_rel  <= 1'b0;
    end else if (stop_req) begin
      st       <= SS_OFF;
      dly_cnt  <= '0;
      ref_code <= '0;
      pwm_rel  <= 1'b0;
    end else begin
      case (st)
        SS_OFF: begin
          if (start_ok) begin
            st      <= SS_DELAY;
            tgt     <= vid;
            dly_cnt <= '0;
          end
        end
        SS_DELAY: begin
          if (dly_last) begin
            st <= SS_RAMP;
          end else if (sw_tick) begin
            dly_cnt <= dly_cnt + DLY_W'(1);
          end
        end
        SS_RAMP: begin
          if (prebias_ok) pwm_rel <= 1'b1;
          if (ref_code == tgt) begin
            st <= SS_DONE;
          end else if (step_tick) begin
            ref_code <= ref_code + VID_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vreg_ss_offset.sv
module vreg_ss_offset
  import vreg_ss_pkg::*;
#(
  parameter int OFS_MAX = 8,
  parameter int OFS_CYC = 640,
  localparam int OFS_W  = cnt_width(OFS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sw_tick,
  output logic [OFS_W-1:0] offset_code
);
  localparam int DIV   = ofs_step_div(OFS_CYC, OFS_MAX);
  localparam int DIV_W = cnt_width(DIV);

  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      offset_code <= OFS_W'(OFS_MAX);
      div_cnt     <= '0;
    end else if (sw_tick && (offset_code != '0)) begin
      if (div_cnt == DIV_W'(DIV - 1)) begin
        offset_code <= offset_code - OFS_W'(1);
        div_cnt     <= '0;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/vreg_softstart.sv
module vreg_softstart
  import vreg_ss_pkg::*;
#(
  parameter int DLY_CYC = 64,
  parameter int OFS_MAX = 8,
  parameter int OFS_CYC = 640,
  parameter int NL_DLY  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           supply_ok,
  input  logic                           en_cmp,
  input  logic                           en_logic,
  input  logic [VID_W-1:0]               vid,
  input  logic                           sw_tick,
  input  logic                           step_tick,
  input  logic                           prebias_ok,
  output logic [VID_W-1:0]               ref_code,
  output logic [$clog2(OFS_MAX+1)-1:0]   offset_code,
  output logic                           pwm_hiz,
  output logic                           ss_done
);
  ss_state_e st;
  logic      start_ok;
  logic      stop_req;
  logic      pwm_rel;
  // named events for the checker
  logic      delay_active;
  logic      run_active;

  vreg_ss_enable #(.NL_DLY(NL_DLY)) u_enable (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_cmp(en_cmp),
    .en_logic(en_logic), .vid(vid), .start_ok(start_ok), .stop_req(stop_req)
  );

  vreg_ss_ramp #(.DLY_CYC(DLY_CYC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .stop_req(stop_req),
    .sw_tick(sw_tick), .step_tick(step_tick), .prebias_ok(prebias_ok),
    .vid(vid), .st(st), .ref_code(ref_code), .pwm_rel(pwm_rel)
  );

  assign delay_active = (st == SS_DELAY);
  assign run_active   = (st == SS_RAMP) || (st == SS_DONE);

  vreg_ss_offset #(.OFS_MAX(OFS_MAX), .OFS_CYC(OFS_CYC)) u_offset (
    .clk(clk), .rst_n(rst_n), .run(run_active && !stop_req),
    .sw_tick(sw_tick), .offset_code(offset_code)
  );

  assign ss_done = (st == SS_DONE);
  assign pwm_hiz = !(pwm_rel || ss_done);
endmodule

// File: rtl/vreg_softstart_chk.sv
module vreg_softstart_chk #(
  parameter int OFS_MAX = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         supply_ok,
  input logic                         en_cmp,
  input logic                         en_logic,
  input logic [5:0]                   ref_code,
  input logic [$clog2(OFS_MAX+1)-1:0] offset_code,
  input logic                         pwm_hiz,
  input logic                         ss_done,
  input logic                         delay_active,
  input logic                         run_active
);
  localparam int OW = $clog2(OFS_MAX + 1);

  assert_lost_enable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok || !en_cmp || !en_logic) |=> (ref_code == 6'd0 && pwm_hiz && !ss_done));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 6'd1
              || ref_code == 6'd0));

  assert_hiz_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    delay_active |-> pwm_hiz);

  assert_done_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> !pwm_hiz);

  assert_full_offset_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    delay_active |-> offset_code == OW'(OFS_MAX));

  assert_offset_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && $past(run_active)) |-> offset_code <= $past(offset_code));

  assert_done_holds_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done && $past(ss_done)) |-> ref_code == $past(ref_code));
endmodule

bind vreg_softstart vreg_softstart_chk #(.OFS_MAX(OFS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_cmp(en_cmp),
  .en_logic(en_logic), .ref_code(ref_code), .offset_code(offset_code),
  .pwm_hiz(pwm_hiz), .ss_done(ss_done), .delay_active(delay_active),
  .run_active(run_active)
);

// File: tb/vreg_softstart_bench.sv
module vreg_softstart_bench;
  localparam int DLY  = 4;
  localparam int OMAX = 4;
  localparam int OCYC = 12;
  localparam int DIV  = OCYC / OMAX;
  localparam int NL   = 2;
  localparam int OW   = $clog2(OMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok, en_cmp, en_logic;
  logic [5:0]    vid;
  logic          sw_tick, step_tick, prebias_ok;
  logic [5:0]    ref_code;
  logic [OW-1:0] offset_code;
  logic          pwm_hiz, ss_done;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  vreg_softstart #(.DLY_CYC(DLY), .OFS_MAX(OMAX), .OFS_CYC(OCYC), .NL_DLY(NL))
    u_vreg_softstart (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_cmp(en_cmp),
    .en_logic(en_logic), .vid(vid), .sw_tick(sw_tick), .step_tick(step_tick),
    .prebias_ok(prebias_ok), .ref_code(ref_code), .offset_code(offset_code),
    .pwm_hiz(pwm_hiz), .ss_done(ss_done)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_off(input string req);
    check({req, " ref"}, int'(ref_code), 0);
    check({req, " hiz"}, int'(pwm_hiz), 1);
    check({req, " done"}, int'(ss_done), 0);
    check({req, " offset"}, int'(offset_code), OMAX);
  endtask

  // drive a start with target t; returns just after the start edge
  task automatic go(input int t);
    @(negedge clk);
    vid = 6'(t); supply_ok = 1; en_cmp = 1; en_logic = 1;
    @(posedge clk);
  endtask

  task automatic stop_all();
    @(negedge clk);
    en_logic = 0;
    @(posedge clk);
    @(negedge clk);
    check_off("R9 stop");
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; supply_ok = 0; en_cmp = 0; en_logic = 0; vid = 6'd0;
    sw_tick = 1; step_tick = 1; prebias_ok = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check_off("R1 reset");

    // R1: each start condition missing in turn
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      supply_ok = (c != 0); en_cmp = (c != 1); en_logic = (c != 2);
      vid = (c == 3) ? 6'h3F : 6'd20;
      repeat (DLY + 20) @(posedge clk);
      @(negedge clk);
      check_off("R1 missing condition");
    end
    @(negedge clk);
    supply_ok = 1; en_cmp = 1; en_logic = 0;

    // R2 R3 R4 R5 R7: sweep every valid target with ticks on every clock
    for (int t = 0; t < 63; t++) begin
      go(t);
      for (int m = 0; m <= DLY + t + OCYC + 2; m++) begin
        int r_e, o_e, d_e;
        @(negedge clk);
        r_e = (m <= DLY) ? 0 : (((m - DLY) < t) ? (m - DLY) : t);
        d_e = (m >= DLY + t + 1) ? 1 : 0;
        o_e = (m <= DLY) ? OMAX : OMAX - (m - DLY) / DIV;
        if (o_e < 0) o_e = 0;
        check("R4 ramp ref", int'(ref_code), r_e);
        check("R5 done timing", int'(ss_done), d_e);
        check("R6 hiz no prebias", int'(pwm_hiz), 1 - d_e);
        check("R7 offset", int'(offset_code), o_e);
        @(posedge clk);
      end
      stop_all();
    end

    // R3: wait counts switching ticks, not clocks
    @(negedge clk);
    sw_tick = 0;
    go(20);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R3 no ticks no ramp", int'(ref_code), 0);
    for (int p = 1; p <= DLY; p++) begin
      sw_tick = 1;
      @(posedge clk);
      @(negedge clk);
      sw_tick = 0;
      @(posedge clk);
      @(negedge clk);
      check("R3 ramp after last tick", int'(ref_code), (p == DLY) ? 1 : 0);
    end
    sw_tick = 1;
    stop_all();

    // R6: prebias ignored in wait, releases in ramp
    @(negedge clk);
    prebias_ok = 1;
    go(40);
    for (int m = 0; m < DLY; m++) begin
      @(negedge clk);
      check("R6 hiz in wait", int'(pwm_hiz), 1);
      @(posedge clk);
    end
    @(negedge clk);
    prebias_ok = 0;
    check("R6 hiz at ramp entry", int'(pwm_hiz), 1);
    @(posedge clk);
    @(negedge clk);
    check("R6 hiz before prebias", int'(pwm_hiz), 1);
    prebias_ok = 1;
    @(posedge clk);
    @(negedge clk);
    prebias_ok = 0;
    check("R6 released", int'(pwm_hiz), 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R6 stays released", int'(pwm_hiz), 0);
    check("R6 not done yet", int'(ss_done), 0);
    stop_all();

    // R9: abort mid-ramp and restart from full wait
    go(20);
    repeat (DLY + 5) @(posedge clk);
    @(negedge clk);
    check("R9 ramp before abort", int'(ref_code), 5);
    en_cmp = 0;
    @(posedge clk);
    @(negedge clk);
    check_off("R9 abort");
    en_cmp = 1;
    @(posedge clk);
    repeat (DLY) @(posedge clk);
    @(negedge clk);
    check("R9 restart full wait", int'(ref_code), 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 restart ramp", int'(ref_code), 1);
    @(negedge clk);
    supply_ok = 0;
    @(posedge clk);
    @(negedge clk);
    check_off("R9 supply lost");
    supply_ok = 1; en_logic = 0;

    // R10: latched target, done holds
    go(10);
    repeat (DLY + 3) @(posedge clk);
    @(negedge clk);
    vid = 6'd30;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R10 target latched", int'(ref_code), 10);
    check("R10 done", int'(ss_done), 1);
    vid = 6'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 done holds", int'(ss_done), 1);
    check("R10 ref holds", int'(ref_code), 10);

    // R8: no-load bursts
    vid = 6'h3F;
    @(posedge clk);
    @(negedge clk);
    vid = 6'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 one-cycle burst ignored", int'(ss_done), 1);
    vid = 6'h3F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 two-cycle burst running", int'(ss_done), 1);
    vid = 6'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 two-cycle burst ignored", int'(ss_done), 1);
    check("R8 ref kept", int'(ref_code), 10);
    vid = 6'h3F;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 still running", int'(ss_done), 1);
    @(posedge clk);
    @(negedge clk);
    check_off("R8 shutdown");
    repeat (10) @(posedge clk);
    @(negedge clk);
    check_off("R8 stays off");
    vid = 6'd5;
    @(posedge clk);
    repeat (DLY + 5) @(posedge clk);
    @(negedge clk);
    check("R8 restart ref", int'(ref_code), 5);
    check("R8 restart not done", int'(ss_done), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 restart done", int'(ss_done), 1);
    stop_all();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule